// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a simple synchronous host port and an external 8K x 8 asynchronous static RAM. When the host raises a request while the controller is ready, the block latches a 13-bit address, a read/write flag and 8-bit write data. It then produces the full pin sequence for one memory cycle: the address bus, an active-low and an active-high chip select, output enable, write enable, and the enable for its own data-bus drivers. When the cycle is over, it signals completion with a one-cycle done pulse. On a read, the captured data is returned with that pulse.

Each timing phase lasts a whole number of clocks. That number is the nanosecond minimum divided by the clock-period parameter, rounded up, and never less than one cycle. Changing the clock period therefore retimes every phase with no edits to the logic. The data drivers turn on only after a turnaround window, and a float window follows every read, so the controller and the memory never drive the bus at the same time. A standby input parks both chip selects in the deselected state while the controller is idle, which gives the memory its low-power mode.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After synchronous reset with standby low, the outputs are as follows: host_ready=1, host_done=0, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0, and the memory is selected (mem_sel_n=0, mem_sel=1).
- R2: While the controller is idle and standby=1, the memory is deselected (mem_sel_n=1, mem_sel=0). During an accepted cycle the memory is selected whatever the value of standby.
- R3: A read holds mem_sel_n=0, mem_sel=1, mem_oe_n=0 and mem_we_n=1, with mem_addr equal to the captured address, for ceil(max(200,100) ns / period) cycles (10 at 20 ns).
- R4: Read data is sampled from mem_dq_in on the last clock edge of the output-enable window. It is presented on host_rdata together with host_done.
- R5: After a read, mem_oe_n=1 and mem_dq_oe=0 hold for ceil(60 ns / period) cycles (3), with the memory still selected, before the controller becomes ready again.
- R6: A write holds mem_we_n=0, with mem_oe_n=1, for max(ceil(150/period), turnaround + ceil(80/period)) cycles (8). Output enable is never low while write enable is low.
- R7: During the write pulse, mem_dq_oe stays 0 for the first ceil(70 ns / period) cycles (4). It then stays 1 until the pulse ends, with mem_dq_out equal to the captured write data. mem_dq_oe is never 1 while mem_oe_n is 0.
- R8: After the write pulse ends, mem_dq_oe=0 while the address and chip select are held for max(ceil(10/period), ceil(200/period) - pulse) cycles (2). A full write therefore takes 10 cycles.
- R9: host_ready is 1 only when idle. host_done is a single-cycle pulse in the first idle cycle after a memory cycle. A request raised while the controller is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request; accepted only when host_ready is 1 |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Word address |
| host_wdata | input | 8 | Write data |
| standby | input | 1 | Deselect the memory while idle |
| host_ready | output | 1 | Controller idle and able to accept a request |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Captured read data |
| mem_addr | output | 13 | Memory address bus |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data the controller drives onto the bus |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 8 | Data read back from the bus |

## Verification
The bench goes after the cycle boundaries of each phase. If a design ended the output-enable window one cycle early, it would sample stale or floating read data. If it enabled the drivers too soon in a write, the controller and the memory could drive the bus at once. If it cut write recovery short, the address would move while the memory is still latching. Requests raised in mid-cycle check for a design that accepts work while busy, which would corrupt the address of the cycle in flight. Standby is toggled around transactions to catch chip selects that park in the wrong state or that stay deselected during a cycle. Reads of unwritten and overwritten locations, at both ends of the address space, show whether data captured at the wrong moment reaches the memory.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int ADDR_W_DEF = 13;
    localparam int DATA_W_DEF = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_ACCESS,
        PH_RD_FLOAT,
        PH_WR_PULSE,
        PH_WR_RECOVER
    } phase_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } pin_ctl_t;

    // Clock cycles that cover a nanosecond minimum, never fewer than one.
    function automatic int cycles_for(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [CW-1:0] len,
    output logic [CW-1:0] cnt,
    output logic          last
);
    assign last = (cnt == (len - CW'(1)));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (!last) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
    import sram_ctl_pkg::*;
#(
    parameter int CW       = 4,
    parameter int TURN_LEN = 4
) (
    input  phase_e        phase,
    input  logic          standby,
    input  logic [CW-1:0] cnt,
    output pin_ctl_t      pins
);
    always_comb begin
        pins = '{sel_n: 1'b0, sel: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
        case (phase)
            PH_IDLE: begin
                pins.sel_n = standby;
                pins.sel   = !standby;
            end
            PH_RD_ACCESS:  pins.oe_n = 1'b0;
            PH_RD_FLOAT:   pins.oe_n = 1'b1;
            PH_WR_PULSE: begin
                pins.we_n  = 1'b0;
                pins.dq_oe = (cnt >= CW'(TURN_LEN));
            end
            PH_WR_RECOVER: pins.we_n = 1'b1;
            default: pins.oe_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W        = ADDR_W_DEF,
    parameter int DATA_W        = DATA_W_DEF,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_RC_NS       = 200,
    parameter int T_ACC_NS      = 200,
    parameter int T_OE_NS       = 100,
    parameter int T_OFF_NS      = 60,
    parameter int T_TURN_NS     = 70,
    parameter int T_WP_NS       = 150,
    parameter int T_WC_NS       = 200,
    parameter int T_DS_NS       = 80,
    parameter int T_WR_NS       = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              standby,
    output logic              host_ready,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int RD_LEN    = imax(imax(cycles_for(T_ACC_NS, CLK_PERIOD_NS),
                                         cycles_for(T_OE_NS, CLK_PERIOD_NS)),
                                    cycles_for(T_RC_NS, CLK_PERIOD_NS) - 1);
    localparam int FLT_LEN   = cycles_for(T_OFF_NS, CLK_PERIOD_NS);
    localparam int TURN_LEN  = cycles_for(T_TURN_NS, CLK_PERIOD_NS);
    localparam int PULSE_LEN = imax(cycles_for(T_WP_NS, CLK_PERIOD_NS),
                                    TURN_LEN + cycles_for(T_DS_NS, CLK_PERIOD_NS));
    localparam int REC_LEN   = imax(cycles_for(T_WR_NS, CLK_PERIOD_NS),
                                    cycles_for(T_WC_NS, CLK_PERIOD_NS) - PULSE_LEN);
    localparam int MAX_LEN   = imax(imax(RD_LEN, FLT_LEN), imax(PULSE_LEN, REC_LEN));
    localparam int CW        = $clog2(MAX_LEN + 1);

    phase_e            phase, phase_nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic [CW-1:0]     ph_len;
    logic [CW-1:0]     ph_cnt;
    logic              ph_last;
    logic              accept;
    pin_ctl_t          pins;

    assign accept = (phase == PH_IDLE) && host_req;

    always_comb begin
        phase_nxt = phase;
        case (phase)
            PH_IDLE:       if (host_req) phase_nxt = host_write ? PH_WR_PULSE : PH_RD_ACCESS;
            PH_RD_ACCESS:  if (ph_last) phase_nxt = PH_RD_FLOAT;
            PH_RD_FLOAT:   if (ph_last) phase_nxt = PH_IDLE;
            PH_WR_PULSE:   if (ph_last) phase_nxt = PH_WR_RECOVER;
            PH_WR_RECOVER: if (ph_last) phase_nxt = PH_IDLE;
            default:       phase_nxt = PH_IDLE;
        endcase
    end

    always_comb begin
        case (phase)
            PH_RD_ACCESS:  ph_len = CW'(RD_LEN);
            PH_RD_FLOAT:   ph_len = CW'(FLT_LEN);
            PH_WR_PULSE:   ph_len = CW'(PULSE_LEN);
            PH_WR_RECOVER: ph_len = CW'(REC_LEN);
            default:       ph_len = CW'(1);
        endcase
    end

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (phase_nxt != phase),
        .len     (ph_len),
        .cnt     (ph_cnt),
        .last    (ph_last)
    );

    sram_pin_decode #(.CW(CW), .TURN_LEN(TURN_LEN)) u_decode (
        .phase   (phase),
        .standby (standby),
        .cnt     (ph_cnt),
        .pins    (pins)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            phase  <= phase_nxt;
            done_q <= (phase != PH_IDLE) && (phase_nxt == PH_IDLE);
            if (accept) begin
                addr_q  <= host_addr;
                wdata_q <= host_wdata;
            end
            if (phase == PH_RD_ACCESS && ph_last) begin
                rdata_q <= mem_dq_in;
            end
        end
    end

    assign host_ready = (phase == PH_IDLE);
    assign host_done  = done_q;
    assign host_rdata = rdata_q;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign mem_sel_n  = pins.sel_n;
    assign mem_sel    = pins.sel;
    assign mem_oe_n   = pins.oe_n;
    assign mem_we_n   = pins.we_n;
    assign mem_dq_oe  = pins.dq_oe;

    // Run-length counters for the timing checks below
    logic [15:0] oe_run, we_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            oe_run <= '0;
            we_run <= '0;
        end else begin
            oe_run <= mem_oe_n ? 16'd0 : oe_run + 16'd1;
            we_run <= mem_we_n ? 16'd0 : we_run + 16'd1;
        end
    end

    AST_STANDBY_PARK: assert property (@(posedge clk) disable iff (rst)
        (host_ready && standby) |-> (mem_sel_n && !mem_sel)); // R2
    AST_RD_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (oe_run >= 16'(RD_LEN))); // R3
    AST_WR_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_run >= 16'(PULSE_LEN))); // R6
    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n); // R6
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (mem_oe_n && !mem_we_n)); // R7
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R7
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((!mem_we_n && $past(!mem_we_n)) || $rose(mem_we_n)) |-> $stable(mem_addr)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        host_done |=> !host_done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        host_done |-> host_ready); // R9

endmodule

// File: tb/test_sram_cycle_ctrl.sv
module test_sram_cycle_ctrl;
    localparam int PER = 20;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD    = mx(cdiv(200), cdiv(100));
    localparam int E_FLT   = cdiv(60);
    localparam int E_TURN  = cdiv(70);
    localparam int E_PULSE = mx(cdiv(150), E_TURN + cdiv(80));
    localparam int E_REC   = mx(cdiv(10), cdiv(200) - E_PULSE);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_write = 1'b0;
    logic [12:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        standby = 1'b0;
    logic        host_ready, host_done;
    logic [7:0]  host_rdata;
    logic [12:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] mem_cells [int];
    logic [7:0] exp_mem [int];

    always #(PER/2) clk = ~clk;

    sram_cycle_ctrl i_sram_cycle_ctrl (
        .clk(clk), .rst(rst), .host_req(host_req), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .standby(standby),
        .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Behavioural memory on the pins
    always @(posedge clk) begin
        if (!mem_sel_n && mem_sel && !mem_we_n && mem_dq_oe)
            mem_cells[int'(mem_addr)] = mem_dq_out;
    end
    always @(negedge clk) begin
        if (!mem_sel_n && mem_sel && !mem_oe_n)
            mem_dq_in <= mem_cells.exists(int'(mem_addr)) ? mem_cells[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in <= 8'h00;
    end

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_sel(input string tag, input logic active);
        check(tag, "mem_sel_n", mem_sel_n, !active);
        check(tag, "mem_sel", mem_sel, active);
    endtask

    task automatic run_op(input bit wr, input logic [12:0] a, input logic [7:0] d, input bit poke);
        logic [7:0] rexp;
        check("R9", "ready before request", host_ready, 1);
        host_req = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_addr = ~a; host_wdata = ~d;
        if (wr) begin
            for (int i = 0; i < E_PULSE + E_REC; i++) begin
                check_sel("R2", 1'b1);
                check("R8", "address held", mem_addr, a);
                check("R9", "ready while busy", host_ready, 0);
                check("R9", "done while busy", host_done, 0);
                check("R6", "oe_n during write", mem_oe_n, 1);
                if (i < E_PULSE) begin
                    check("R6", "we_n in pulse", mem_we_n, 0);
                    check("R7", "drive enable in pulse", mem_dq_oe, (i >= E_TURN));
                    if (i >= E_TURN) check("R7", "write data", mem_dq_out, d);
                end else begin
                    check("R8", "we_n in recovery", mem_we_n, 1);
                    check("R8", "drive off in recovery", mem_dq_oe, 0);
                end
                if (poke && i == 2) begin host_req = 1'b1; host_write = !wr; end
                if (poke && i == 3) host_req = 1'b0;
                @(negedge clk);
            end
            exp_mem[int'(a)] = d;
        end else begin
            for (int i = 0; i < E_RD; i++) begin
                check_sel("R2", 1'b1);
                check("R3", "oe_n in access", mem_oe_n, 0);
                check("R3", "we_n in access", mem_we_n, 1);
                check("R3", "address", mem_addr, a);
                check("R7", "no drive in read", mem_dq_oe, 0);
                check("R9", "ready while busy", host_ready, 0);
                if (poke && i == 2) begin host_req = 1'b1; host_write = !wr; end
                if (poke && i == 3) host_req = 1'b0;
                @(negedge clk);
            end
            for (int i = 0; i < E_FLT; i++) begin
                check_sel("R5", 1'b1);
                check("R5", "oe_n in float", mem_oe_n, 1);
                check("R5", "no drive in float", mem_dq_oe, 0);
                check("R5", "ready in float", host_ready, 0);
                check("R9", "done in float", host_done, 0);
                @(negedge clk);
            end
        end
        check("R9", "done pulse", host_done, 1);
        check("R9", "ready at done", host_ready, 1);
        check_sel("R2", !standby);
        if (!wr) begin
            rexp = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00;
            check("R4", "read data", host_rdata, rexp);
        end
        @(negedge clk);
        check("R9", "done cleared", host_done, 0);
        check("R9", "no extra cycle", mem_we_n & mem_oe_n & host_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "ready", host_ready, 1);
        check("R1", "done", host_done, 0);
        check("R1", "oe_n", mem_oe_n, 1);
        check("R1", "we_n", mem_we_n, 1);
        check("R1", "dq_oe", mem_dq_oe, 0);
        check_sel("R1", 1'b1);

        standby = 1'b1;
        @(negedge clk);
        check_sel("R2", 1'b0);

        run_op(1'b1, 13'h0000, 8'h5A, 1'b0);
        run_op(1'b1, 13'h1FFF, 8'hA5, 1'b1);
        standby = 1'b0;
        @(negedge clk);
        check_sel("R2", 1'b1);
        run_op(1'b1, 13'h1555, 8'hFF, 1'b0);
        run_op(1'b0, 13'h0000, 8'h00, 1'b0);
        run_op(1'b0, 13'h1FFF, 8'h00, 1'b1);
        run_op(1'b0, 13'h0AAA, 8'h00, 1'b0);
        run_op(1'b1, 13'h1555, 8'h3C, 1'b0);
        run_op(1'b0, 13'h1555, 8'h00, 1'b0);
        standby = 1'b1;
        for (int k = 0; k < 8; k++) begin
            run_op(1'b1, 13'(k * 1021), 8'(k * 37 + 1), 1'b0);
            run_op(1'b0, 13'(k * 1021), 8'h00, 1'b0);
        end
        check_sel("R2", 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R9 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule